// File: doc/BRIEF.md
# Newton-iteration square root unit

This block returns the square root of an unsigned fixed-point operand. It uses a small multicycle datapath driven by a hardwired controller. A single pulse on `start` captures the operand. The controller then forms a straight-line starting estimate and applies four Newton refinements, each of which takes the mean of the current estimate and the operand divided by that estimate. When the result is ready, `done` pulses for one cycle.

The datapath is deliberately minimal:

- One registered unit that either multiplies in a single cycle or divides sequentially, restoring one quotient bit per cycle.
- One adder, which also carries a small incrementer for the loop count.
- A halving step that costs no hardware, because it is only a wiring shift.
- A two-bit loop counter.

Each control step is one controller state. The divide counts as a single control step, and the controller stalls in it until the divider reports that it has finished.

Operands and results are Q2.14: two integer bits and fourteen fraction bits, so the value 1.0 is encoded as 16384. Results are guaranteed only for inputs in the range 1/16 to 1, that is codes 1024 to 16384.

Top module: `newton_sqrt`

## Requirements
- R1: While reset is held and in the cycle after it is released, `done` is 0 and `y_out` is 0.
- R2: The start estimate is Y0 = C0 + floor(C1·X / 2^14). C0 = round(2/9·2^14) = 3641 and C1 = round(8/9·2^14) = 14564, so the estimate is about 0.2222 + 0.8889·X.
- R3: Each refinement computes Y ← floor((Y + Q)/2), where Q = floor(X·2^14 / Y) truncated to 16 bits. The halving is a one-bit right shift of the 17-bit sum.
- R4: Exactly four refinements run. A 2-bit counter is cleared before the loop, is incremented in every update step, and ends the loop when it wraps back to 0.
- R5: For every X from 1024 to 16384, `y_out` lies within 2 LSB of sqrt(X/2^14)·2^14.
- R6: `done` is high for exactly one cycle. `y_out` carries the result in that cycle and keeps it until the next accepted start.
- R7: A `start` that arrives while a computation is running is ignored. Neither the result nor the completion time changes, and no extra `done` appears.
- R8: The schedule is multiply, add, then four pairs of divide and update. Each divide occupies 32 cycles: one issue cycle, 30 bit steps (one per bit of the 30-bit dividend), and one handover cycle. `done` is therefore observed 134 clock edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse; `x_in` is captured in the same cycle when idle |
| x_in | input | 16 | Operand X, unsigned Q2.14 |
| done | output | 1 | One-cycle completion pulse |
| y_out | output | 16 | Square root result, unsigned Q2.14 |

## Verification
The bench probes both ends of the valid input range and the perfect squares 0.25, 0.5625 and 1.0. A wrong seed constant or a misplaced multiply slice would fail these, because the stated rounding makes the exact code predictable. A loop that ran three or five times, or that compared its counter instead of waiting for the wrap, would leave a residual error and shift the completion edge; both show up in the bit-exact compare and the latency count. A second `start` with a different operand is injected mid-run: a controller that re-armed, or an operand register that was not frozen, would change the result or add a `done`. After every run the bench confirms that `done` is a single pulse and that `y_out` stays put.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;

   // one controller state per control step
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_MUL  = 3'd1,
      ST_SEED = 3'd2,
      ST_DIV  = 3'd3,
      ST_UPD  = 3'd4
   } sqrt_state_e;

endpackage

// File: rtl/sqrt_muldiv.sv
// Registered multiply / sequential restoring divide unit sharing one result register.
module sqrt_muldiv #(
   parameter int W    = 16,
   parameter int FRAC = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         do_mul,
   input  logic         do_div,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic [W-1:0] res,
   output logic         ready
);
   localparam int NW = W + FRAC;
   localparam int CW = $clog2(NW + 1);

   if (FRAC >= W) begin : g_bad_frac
      $error("sqrt_muldiv: FRAC must be below W");
   end

   logic [2*W-1:0] prod_w;
   logic [NW-1:0]  num_q;
   logic [W-1:0]   rem_q, dvs_q, quo_q, rem_n, quo_n;
   logic [W:0]     rem_sh, rem_sub;
   logic           ge;
   logic [CW-1:0]  cnt_q;
   logic           busy_q;

   assign prod_w  = opa * opb;
   assign rem_sh  = {rem_q, num_q[NW-1]};
   assign ge      = rem_sh >= {1'b0, dvs_q};
   assign rem_sub = rem_sh - {1'b0, dvs_q};
   assign rem_n   = ge ? W'(rem_sub) : W'(rem_sh);
   assign quo_n   = W'({quo_q, ge});

   always_ff @(posedge clk) begin
      if (rst) begin
         res    <= '0;
         ready  <= 1'b0;
         busy_q <= 1'b0;
         cnt_q  <= '0;
         num_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         quo_q  <= '0;
      end else begin
         ready <= 1'b0;
         if (do_mul) begin
            res <= W'(prod_w >> FRAC);
         end else if (do_div) begin
            num_q  <= {opa, {FRAC{1'b0}}};
            dvs_q  <= opb;
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= CW'(NW);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            num_q <= num_q << 1;
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               res    <= quo_n;
               ready  <= 1'b1;
               busy_q <= 1'b0;
            end
         end
      end
   end

   // R8: completion is a single pulse per divide
   p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      ready |=> !ready);
   // R8: no new operation is issued while the divider is stepping
   p_no_issue_busy_r8: assert property (@(posedge clk) disable iff (rst)
      busy_q |-> !(do_div || do_mul));
   // R3: the divisor presented to the unit is never zero
   p_divisor_nz_r3: assert property (@(posedge clk) disable iff (rst)
      do_div |-> (opb != '0));
endmodule

// File: rtl/sqrt_addinc.sv
// Adder for seed/update plus the loop-counter incrementer.
module sqrt_addinc #(
   parameter int W     = 16,
   parameter int CNT_W = 2
) (
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic [CNT_W-1:0] cnt,
   output logic [W:0]       sum,
   output logic [CNT_W-1:0] cnt_inc
);
   assign sum     = a + b;
   assign cnt_inc = cnt + CNT_W'(1);
endmodule

// File: rtl/sqrt_ctrl.sv
// Hardwired controller: one state per control step, stalls in ST_DIV.
module sqrt_ctrl
   import sqrt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic div_ready,
   input  logic cnt_wrap,
   output logic ld_x,
   output logic do_mul,
   output logic do_div,
   output logic sel_y,
   output logic ld_y,
   output logic y_shift,
   output logic cnt_clr,
   output logic cnt_en,
   output logic busy,
   output logic done
);
   sqrt_state_e state_q, state_d;
   logic        issued_q, issued_d;

   always_comb begin
      state_d  = state_q;
      issued_d = issued_q;
      ld_x     = 1'b0;
      do_mul   = 1'b0;
      do_div   = 1'b0;
      sel_y    = 1'b0;
      ld_y     = 1'b0;
      y_shift  = 1'b0;
      cnt_clr  = 1'b0;
      cnt_en   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            ld_x = start;
            if (start) state_d = ST_MUL;
         end
         ST_MUL: begin
            do_mul  = 1'b1;
            cnt_clr = 1'b1;
            state_d = ST_SEED;
         end
         ST_SEED: begin
            ld_y    = 1'b1;
            state_d = ST_DIV;
         end
         ST_DIV: begin
            if (!issued_q) begin
               do_div   = 1'b1;
               issued_d = 1'b1;
            end else if (div_ready) begin
               issued_d = 1'b0;
               state_d  = ST_UPD;
            end
         end
         ST_UPD: begin
            sel_y   = 1'b1;
            ld_y    = 1'b1;
            y_shift = 1'b1;
            cnt_en  = 1'b1;
            state_d = cnt_wrap ? ST_IDLE : ST_DIV;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         issued_q <= 1'b0;
         done     <= 1'b0;
      end else begin
         state_q  <= state_d;
         issued_q <= issued_d;
         done     <= (state_q == ST_UPD) && cnt_wrap;
      end
   end

   assign busy = (state_q != ST_IDLE);

   // R6: completion pulse lasts one cycle
   p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R4: completion only follows an update step
   p_done_after_upd_r4: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(state_q == ST_UPD));
   // R7: a request while busy never re-enters the first step
   p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
      (busy && state_q != ST_UPD) |=> state_q != ST_MUL);
endmodule

// File: rtl/newton_sqrt.sv
// Newton square root: seed by linear fit, four halving-mean refinements.
module newton_sqrt #(
   parameter int W     = 16,
   parameter int FRAC  = 14,
   parameter int CNT_W = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic [W-1:0] x_in,
   output logic         done,
   output logic [W-1:0] y_out
);
   localparam int ONE_I = 2 ** FRAC;
   localparam int C0_I  = (ONE_I * 2 + 4) / 9;
   localparam int C1_I  = (ONE_I * 8 + 4) / 9;
   localparam logic [W-1:0] C0_L = W'(C0_I);
   localparam logic [W-1:0] C1_L = W'(C1_I);

   if (W < FRAC + 2) begin : g_bad_width
      $error("newton_sqrt: need at least two integer bits");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("newton_sqrt: loop counter needs a bit");
   end

   logic [W-1:0]     x_q, y_q, y_d, md_a, md_b, md_res, add_a;
   logic [W:0]       sum;
   logic [CNT_W-1:0] cnt_q, cnt_inc;
   logic ld_x, do_mul, do_div, sel_y, ld_y, y_shift, cnt_clr, cnt_en, busy;
   logic div_ready, cnt_wrap;

   sqrt_ctrl u_ctrl (
      .clk, .rst, .start, .div_ready, .cnt_wrap,
      .ld_x, .do_mul, .do_div, .sel_y, .ld_y, .y_shift,
      .cnt_clr, .cnt_en, .busy, .done
   );

   assign md_a = do_mul ? C1_L : x_q;
   assign md_b = do_mul ? x_q  : y_q;

   sqrt_muldiv #(.W(W), .FRAC(FRAC)) u_md (
      .clk, .rst, .do_mul, .do_div,
      .opa(md_a), .opb(md_b), .res(md_res), .ready(div_ready)
   );

   assign add_a = sel_y ? y_q : C0_L;

   sqrt_addinc #(.W(W), .CNT_W(CNT_W)) u_add (
      .a(add_a), .b(md_res), .cnt(cnt_q), .sum, .cnt_inc
   );

   assign y_d      = y_shift ? W'(sum >> 1) : W'(sum);
   assign cnt_wrap = (cnt_inc == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q   <= '0;
         y_q   <= '0;
         cnt_q <= '0;
      end else begin
         if (ld_x) x_q <= x_in;
         if (ld_y) y_q <= y_d;
         if (cnt_clr)     cnt_q <= '0;
         else if (cnt_en) cnt_q <= cnt_inc;
      end
   end

   assign y_out = y_q;

   // R7: the operand register is frozen during a computation
   p_x_frozen_r7: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(x_q));
   // R6: the result holds while idle
   p_y_held_r6: assert property (@(posedge clk) disable iff (rst)
      !busy |=> $stable(y_q));
   // R4: the update that wraps the counter is the one that completes
   p_wrap_ends_r4: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && cnt_q == '1) |=> done);
   // R4: no completion without the counter having wrapped
   p_done_wrapped_r4: assert property (@(posedge clk) disable iff (rst)
      done |-> (cnt_q == '0));
endmodule

// File: tb/sim_newton_sqrt.sv
module sim_newton_sqrt;
   localparam int LAT_EXP = 2 + 4 * (30 + 2 + 1);

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] x_in = '0;
   logic        done;
   logic [15:0] y_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   newton_sqrt u0 (.clk, .rst, .start, .x_in, .done, .y_out);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bit-exact reference from R2/R3/R4
   function automatic int model(input int x);
      int c0 = int'(2.0 / 9.0 * 16384.0 + 0.5);
      int c1 = int'(8.0 / 9.0 * 16384.0 + 0.5);
      int y  = (c0 + ((c1 * x) >> 14)) & 16'hFFFF;
      for (int i = 0; i < 4; i++) begin
         longint q = ((longint'(x) << 14) / y) & 16'hFFFF;
         y = int'((longint'(y) + q) >> 1) & 16'hFFFF;
      end
      return y;
   endfunction

   task automatic run_op(input int xv, input bit spoil);
      int lat = 0;
      int extra = 0;
      int exp_y = model(xv);
      real ideal, diff;
      logic [15:0] held;
      @(negedge clk); start = 1'b1; x_in = 16'(xv);
      @(negedge clk); start = 1'b0; x_in = 16'($urandom);
      while (!done && lat < 1000) begin
         @(negedge clk);
         lat++;
         if (spoil && lat == 7) begin
            start = 1'b1; x_in = 16'(1024 + ($urandom % 15361));
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      check(lat == LAT_EXP, "R8 latency", lat, LAT_EXP);
      check(int'(y_out) == exp_y, spoil ? "R7 result with mid-run start" : "R2/R3/R4 exact result",
            int'(y_out), exp_y);
      ideal = $sqrt(real'(xv) / 16384.0) * 16384.0;
      diff  = real'(y_out) - ideal;
      if (diff < 0.0) diff = -diff;
      check(diff <= 2.0, "R5 accuracy", int'(y_out), int'(ideal + 0.5));
      held = y_out;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (done) extra++;
         if (y_out != held) extra++;
      end
      check(extra == 0, spoil ? "R7 no extra done / R6 hold" : "R6 pulse and hold", extra, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 done in reset", int'(done), 0);
      rst = 1'b0;
      @(negedge clk);
      check(done == 1'b0, "R1 done after reset", int'(done), 0);
      check(y_out == 16'd0, "R1 y_out after reset", int'(y_out), 0);

      run_op(1024, 1'b0);    // low end of range
      run_op(16384, 1'b0);   // high end of range
      run_op(4096, 1'b0);    // 0.25 -> 0.5
      run_op(9216, 1'b0);    // 0.5625 -> 0.75
      run_op(1025, 1'b0);
      run_op(16383, 1'b0);
      run_op(5000, 1'b1);    // R7 start while busy
      run_op(12000, 1'b1);
      for (int i = 0; i < 40; i++) begin
         run_op(1024 + int'($urandom % 15361), (i % 8) == 3);
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule